// File: doc/BRIEF.md
# Byte-Select SRAM Bus Interface

This block sits between an internal request port and an external 16-bit asynchronous static RAM. That RAM has separate select inputs for its upper and lower byte. The block takes one request at a time, with an address, write data, a per-byte enable pair and a direction flag. It plays that request out as a chip-select framed pin cycle and returns read data together with a one-clock completion pulse. The data bus leaves the block as three core-side signals: output data, output enable and input data. The pad ring combines them into the bidirectional pins.

Two strobe schemes are selected by a mode input, which is sampled when a request is accepted:

- **Mode 0 (the reset value).** The two byte-select pins are the timed strobes, for writes and also for reads. RD/WR stays low as a direction level for the whole of a write.
- **Mode 1.** The byte-select pins are held low as plain selects for the whole access. RD/WR becomes the write strobe. A 2-bit hold count keeps write data on the bus for extra cycles after RD/WR rises.

In both modes a wait count lengthens the strobe phase.

Top module: `bsram_if`

## Requirements
- R1: While reset is applied, and afterwards with no request, `mem_cs_n`, `mem_rd_n`, `mem_rdwr_n` and both `mem_bs_n` bits are high (all strobes active low), `mem_dq_oe` is 0 and `rsp_done` is 0.
- R2: In the first cycle of chip select, `mem_rd_n` is high. In mode 0 both byte-select pins are also high in that cycle, and in mode 1 `mem_rdwr_n` is high.
- R3: Chip select stays low for exactly one cycle after the last strobe or hold cycle. That cycle carries `rsp_done`. The low time of chip select is 3 + W cycles, plus H for a mode 1 write, where W is `cfg_wait` and H is `cfg_hold`.
- R4: The strobe phase lasts 1 + W cycles. Its strobe is `mem_rd_n` on reads, the byte-select pins on mode 0 writes and `mem_rdwr_n` on mode 1 writes.
- R5: In a mode 0 write, `mem_rdwr_n` is low for the whole chip-select time. Each enabled byte-select pin pulses low only during the strobe phase. Only the enabled bytes of the memory word change.
- R6: In a mode 0 read, each enabled byte-select pin is low during the strobe phase, together with `mem_rd_n`.
- R7: In mode 1, each enabled byte-select pin is low for the whole chip-select time and holds steady. `mem_rdwr_n` is low only in the strobe phase of a write and stays high on reads.
- R8: In a mode 1 write, data stays driven for H + 1 cycles after `mem_rdwr_n` rises, which is H hold cycles plus the closing cycle. H is 0 to 3. Hold cycles never occur in reads or in mode 0.
- R9: `mem_dq_oe` is 1 only during the chip-select time of a write. It is 0 during every read cycle and while idle.
- R10: Read data is sampled from `mem_dq_in` on the last strobe cycle and is valid on `rsp_rdata` while `rsp_done` is high. Bits 15:8 belong to `req_be[1]` and bits 7:0 to `req_be[0]`. A byte that is not enabled reads as 0x00.
- R11: A request with `req_be` = 00 raises `rsp_done` in the next cycle and never asserts chip select.
- R12: `req_valid` is ignored while an access is in progress. Changes to `cfg_mode`, `cfg_wait` and `cfg_hold` after acceptance do not affect the running access.
- R13: `rsp_done` is high for exactly one cycle per accepted request and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit 1 = upper byte |
| cfg_mode | input | 1 | Strobe scheme: 0 byte pins strobe, 1 RD/WR strobes writes |
| cfg_wait | input | WAIT_W | Extra strobe-phase cycles |
| cfg_hold | input | HOLD_W | Mode 1 write data hold cycles |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_rdwr_n | output | 1 | RD/WR pin, low for write |
| mem_bs_n | output | DATA_W/8 | Byte select / write strobe per byte, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data to the pad |
| mem_dq_oe | output | 1 | Pad output enable |
| mem_dq_in | input | DATA_W | Data from the pad |

## Verification
The function is exercised with the following patterns:

- **Byte enables 11, 01 and 10 in both modes.** A missing or swapped byte-select shows up twice: as a wrong byte in the memory model and as a zeroed lane in read data.
- **Wait counts 0, 1, 2, 3 and 15.** These separate a correct strobe-phase length from a counter that is off by one or truncated.
- **Hold counts 0, 2 and 3 on mode 1 writes, and hold 3 on a mode 1 read.** These tell a hold applied to writes only from one that is applied always or never.
- **Enable 00 and a request raised mid-access while the configuration changes.** These confirm that the idle shortcut works and that the running access keeps its own settings.

// File: rtl/bsram_pkg.sv
// Shared types for the byte-select SRAM interface.
package bsram_pkg;

    // Sequencer phases of one external access.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,  // no access, all pins inactive
        ST_SETUP  = 3'd1,  // chip select low, strobes not yet active
        ST_STROBE = 3'd2,  // strobe phase, 1 + wait cycles
        ST_HOLD   = 3'd3,  // mode 1 write data hold after RD/WR rises
        ST_TAIL   = 3'd4,  // closing cycle, chip select still low, done
        ST_SKIP   = 3'd5   // zero byte-enable request, done without bus cycle
    } bsram_state_e;

endpackage

// File: rtl/bsram_ctrl.sv
// Access sequencer.
// Accepts a request when idle, latches the strobe configuration, and steps
// through setup, strobe, optional hold and tail phases using a single
// down-counter. Assumes the request fields are valid in the cycle req_valid
// is high; later changes to the configuration inputs are not observed.
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_be,
    input  logic              cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    output bsram_state_e      state,
    output logic              idle,
    output logic              accept,
    output logic              mode_q,
    output logic              wr_q,
    output logic              last_strobe
);

    localparam int CNT_W = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    bsram_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [WAIT_W-1:0] wait_q;
    logic [HOLD_W-1:0] hold_q;

    assign idle        = (state_q == ST_IDLE);
    assign accept      = idle && req_valid;
    assign last_strobe = (state_q == ST_STROBE) && (cnt_q == '0);
    assign state       = state_q;

    // Capture direction and timing configuration at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            wr_q   <= 1'b0;
            wait_q <= '0;
            hold_q <= '0;
        end else if (accept) begin
            mode_q <= cfg_mode;
            wr_q   <= req_write;
            wait_q <= cfg_wait;
            hold_q <= cfg_hold;
        end
    end

    // Next phase and phase counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) state_d = (req_be == '0) ? ST_SKIP : ST_SETUP;
            end
            ST_SETUP: begin
                state_d = ST_STROBE;
                cnt_d   = CNT_W'(wait_q);
            end
            ST_STROBE: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - CNT_ONE;
                end else if (mode_q && wr_q && (hold_q != '0)) begin
                    state_d = ST_HOLD;
                    cnt_d   = CNT_W'(hold_q) - CNT_ONE;
                end else begin
                    state_d = ST_TAIL;
                end
            end
            ST_HOLD: begin
                if (cnt_q != '0) cnt_d = cnt_q - CNT_ONE;
                else             state_d = ST_TAIL;
            end
            ST_TAIL, ST_SKIP: state_d = ST_IDLE;
            default:          state_d = ST_IDLE;
        endcase
    end

    // Phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Hold phase exists only for mode 1 writes.
    assert_hold_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (mode_q && wr_q));

    // Hold counter never exceeds the programmed hold count.
    assert_hold_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q < CNT_W'(hold_q)));

    // Strobe counter stays within the programmed wait.
    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STROBE) |-> (cnt_q <= CNT_W'(wait_q)));

    // A strobe phase with count remaining continues.
    assert_strobe_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_STROBE) && (cnt_q != '0)) |=> (state_q == ST_STROBE));

endmodule

// File: rtl/bsram_strobe_gen.sv
// Pin decoder.
// Derives chip select, read strobe, RD/WR, per-byte selects and the data
// output enable from the registered sequencer phase and the latched mode.
// Assumes its inputs all come from registers, so the pins are glitch-free
// decodes of stable state.
module bsram_strobe_gen
    import bsram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  bsram_state_e     state,
    input  logic             mode_q,
    input  logic             wr_q,
    input  logic [LANES-1:0] be_q,
    output logic             cs_n,
    output logic             rd_n,
    output logic             rdwr_n,
    output logic [LANES-1:0] bs_n,
    output logic             dq_oe
);

    logic in_cycle;
    logic strobe_ph;

    // Phase classification shared by all pins.
    always_comb begin
        in_cycle  = (state == ST_SETUP) || (state == ST_STROBE) ||
                    (state == ST_HOLD)  || (state == ST_TAIL);
        strobe_ph = (state == ST_STROBE);
    end

    // Shared control pins.
    always_comb begin
        cs_n   = ~in_cycle;
        rd_n   = ~(strobe_ph && !wr_q);
        rdwr_n = mode_q ? ~(strobe_ph && wr_q) : ~(in_cycle && wr_q);
        dq_oe  = in_cycle && wr_q;
    end

    // One select per byte lane: strobe in mode 0, steady select in mode 1.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign bs_n[i] = ~(be_q[i] && (mode_q ? in_cycle : strobe_ph));
    end

endmodule

// File: rtl/bsram_datapath.sv
// Address, write data and read capture.
// Latches the request address, data and byte enables on acceptance, presents
// them to the pins for the whole access, and captures each enabled read lane
// on the last strobe cycle (disabled lanes read as zero). Assumes DATA_W is a
// multiple of 8.
module bsram_datapath #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              last_strobe,
    input  logic              wr_q,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q,
    output logic [DATA_W-1:0] rdata_q
);

    // Hold request fields for the duration of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
        end
    end

    // Per-lane read capture with masking of disabled bytes.
    for (genvar i = 0; i < LANES; i++) begin : g_rd
        always_ff @(posedge clk) begin
            if (!rst_n)
                rdata_q[i*8 +: 8] <= 8'h00;
            else if (last_strobe && !wr_q)
                rdata_q[i*8 +: 8] <= be_q[i] ? dq_in[i*8 +: 8] : 8'h00;
        end
    end

endmodule

// File: rtl/bsram_if.sv
// Byte-select SRAM interface top.
// Converts single internal requests into chip-select framed cycles for a
// 16-bit asynchronous SRAM with per-byte selects. The data bus is split into
// output, output enable and input for the pad ring. Assumes one request at a
// time; requests raised while busy are dropped.
module bsram_if
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 2,
    localparam int LANES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              cfg_mode,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_cs_n,
    output logic              mem_rd_n,
    output logic              mem_rdwr_n,
    output logic [LANES-1:0]  mem_bs_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    bsram_state_e     state;
    logic             idle;
    logic             accept;
    logic             mode_q;
    logic             wr_q;
    logic             last_strobe;
    logic [LANES-1:0] be_q;

    bsram_ctrl #(
        .LANES  (LANES),
        .WAIT_W (WAIT_W),
        .HOLD_W (HOLD_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_be      (req_be),
        .cfg_mode    (cfg_mode),
        .cfg_wait    (cfg_wait),
        .cfg_hold    (cfg_hold),
        .state       (state),
        .idle        (idle),
        .accept      (accept),
        .mode_q      (mode_q),
        .wr_q        (wr_q),
        .last_strobe (last_strobe)
    );

    bsram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) dpath_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .last_strobe (last_strobe),
        .wr_q        (wr_q),
        .dq_in       (mem_dq_in),
        .addr_q      (mem_addr),
        .wdata_q     (mem_dq_out),
        .be_q        (be_q),
        .rdata_q     (rsp_rdata)
    );

    bsram_strobe_gen #(
        .LANES (LANES)
    ) pins_i (
        .state  (state),
        .mode_q (mode_q),
        .wr_q   (wr_q),
        .be_q   (be_q),
        .cs_n   (mem_cs_n),
        .rd_n   (mem_rd_n),
        .rdwr_n (mem_rdwr_n),
        .bs_n   (mem_bs_n),
        .dq_oe  (mem_dq_oe)
    );

    // Completion on the closing cycle or the zero-enable shortcut.
    assign rsp_done = (state == ST_TAIL) || (state == ST_SKIP);

    // Idle sequencer leaves every pin inactive.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (mem_cs_n && mem_rd_n && mem_rdwr_n && (&mem_bs_n) && !mem_dq_oe && !rsp_done));

    // First chip-select cycle carries no active strobe.
    assert_cs_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (mem_rd_n && (mode_q ? mem_rdwr_n : (&mem_bs_n))));

    // Chip select releases only after the done cycle.
    assert_cs_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> $past(rsp_done));

    // Mode 1 byte selects do not move inside an access.
    assert_m1_bs_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && !mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_bs_n));

    // Never drive the bus while the read strobe is active.
    assert_read_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dq_oe);

    // Zero-enable request finishes next cycle without chip select.
    assert_null_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_be == '0)) |=> (rsp_done && mem_cs_n));

    // Completion is a single-cycle pulse.
    assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

endmodule

// File: tb/bsram_if_tb_top.sv
// Scoreboard bench: the driver pushes expected per-access pin statistics and
// read data; a negedge monitor counts pin activity, models the SRAM and
// compares on every completion pulse.
module bsram_if_tb_top;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int WAIT_W = 4;
    localparam int HOLD_W = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic [1:0]        req_be;
    logic              cfg_mode;
    logic [WAIT_W-1:0] cfg_wait;
    logic [HOLD_W-1:0] cfg_hold;
    logic              rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic              mem_cs_n, mem_rd_n, mem_rdwr_n, mem_dq_oe;
    logic [1:0]        mem_bs_n;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_dq_out;
    logic [DATA_W-1:0] mem_dq_in;

    always #10 clk = ~clk;

    bsram_if #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_mode(cfg_mode), .cfg_wait(cfg_wait), .cfg_hold(cfg_hold),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_cs_n(mem_cs_n),
        .mem_rd_n(mem_rd_n), .mem_rdwr_n(mem_rdwr_n), .mem_bs_n(mem_bs_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // SRAM model storage and bench reference image.
    logic [15:0] sram    [256];
    logic [15:0] ref_mem [256];

    // SRAM drives a lane only while selected and read-strobed; else filler.
    assign mem_dq_in[15:8] = (!mem_cs_n && !mem_rd_n && mem_rdwr_n && !mem_bs_n[1]) ? sram[mem_addr][15:8] : 8'hEE;
    assign mem_dq_in[7:0]  = (!mem_cs_n && !mem_rd_n && mem_rdwr_n && !mem_bs_n[0]) ? sram[mem_addr][7:0]  : 8'hEE;

    typedef struct {
        bit          is_read;
        bit          is_null;
        bit          mode;
        bit          r12;
        logic [15:0] rdata;
        int          cs, rd, rdwr, bs1, bs0, hold, oe;
    } exp_t;

    exp_t q[$];
    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Monitor: pin statistics, SRAM writes, scoreboard compare.
    int  c_cs, c_rd, c_rdwr, c_bs1, c_bs0, c_hold, c_oe;
    bit  seen_wr, prev_cs_n;
    bit  [1:0] prev_we;

    always @(negedge clk) begin
        bit [1:0] we_now;
        if (!rst_n) begin
            c_cs = 0; c_rd = 0; c_rdwr = 0; c_bs1 = 0; c_bs0 = 0; c_hold = 0; c_oe = 0;
            seen_wr = 0; prev_cs_n = 1; prev_we = 2'b00;
        end else begin
            for (int i = 0; i < 2; i++) begin
                we_now[i] = !mem_cs_n && !mem_rdwr_n && !mem_bs_n[i];
                if (prev_we[i] && !we_now[i]) begin
                    chk("R8", "data driven at write end", int'(mem_dq_oe), 1);
                    sram[mem_addr][i*8 +: 8] = mem_dq_out[i*8 +: 8];
                end
            end
            prev_we = we_now;
            if (prev_cs_n && !mem_cs_n && q.size() != 0)
                chk("R2", "strobes idle in first cs cycle",
                    int'(mem_rd_n && (q[0].mode ? mem_rdwr_n : (&mem_bs_n))), 1);
            prev_cs_n = mem_cs_n;
            if (!mem_cs_n) begin
                c_cs++;
                if (!mem_rd_n)   c_rd++;
                if (!mem_rdwr_n) begin c_rdwr++; seen_wr = 1; end
                if (!mem_bs_n[1]) c_bs1++;
                if (!mem_bs_n[0]) c_bs0++;
                if (mem_dq_oe) c_oe++;
                if (mem_dq_oe && mem_rdwr_n && seen_wr) c_hold++;
            end
            if (rsp_done) begin
                if (q.size() == 0) begin
                    chk("R13", "done without pending request", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(e.is_null ? "R11" : (e.r12 ? "R12" : "R3"), "cs low cycles", c_cs, e.cs);
                    chk("R4", "read strobe cycles", c_rd, e.rd);
                    chk(e.mode ? "R7" : "R5", "rdwr low cycles", c_rdwr, e.rdwr);
                    chk(e.mode ? "R7" : (e.is_read ? "R6" : "R5"), "upper select cycles", c_bs1, e.bs1);
                    chk(e.mode ? "R7" : (e.is_read ? "R6" : "R5"), "lower select cycles", c_bs0, e.bs0);
                    chk("R8", "hold cycles after rdwr rise", c_hold, e.hold);
                    chk("R9", "output enable cycles", c_oe, e.oe);
                    if (e.is_read && !e.is_null)
                        chk(e.r12 ? "R12" : "R10", "read data", int'(rsp_rdata), int'(e.rdata));
                end
                c_cs = 0; c_rd = 0; c_rdwr = 0; c_bs1 = 0; c_bs0 = 0; c_hold = 0; c_oe = 0;
                seen_wr = 0;
            end
        end
    end

    // Driver: compute expectations from the requirements and issue a request.
    task automatic issue(input bit wr, input logic [7:0] a, input logic [15:0] d,
                         input logic [1:0] be, input bit mode, input int w, input int h, input bit r12);
        exp_t e;
        int hh;
        hh = (mode && wr) ? h : 0;
        e.is_read = !wr; e.is_null = (be == 2'b00); e.mode = mode; e.r12 = r12;
        e.rdata = ref_mem[a] & {{8{be[1]}}, {8{be[0]}}};
        if (e.is_null) begin
            e.cs = 0; e.rd = 0; e.rdwr = 0; e.bs1 = 0; e.bs0 = 0; e.hold = 0; e.oe = 0;
        end else begin
            e.cs   = 3 + w + hh;
            e.rd   = wr ? 0 : 1 + w;
            e.rdwr = wr ? (mode ? 1 + w : e.cs) : 0;
            e.bs1  = be[1] ? (mode ? e.cs : 1 + w) : 0;
            e.bs0  = be[0] ? (mode ? e.cs : 1 + w) : 0;
            e.hold = (wr && mode) ? hh + 1 : 0;
            e.oe   = wr ? e.cs : 0;
            if (wr) begin
                if (be[1]) ref_mem[a][15:8] = d[15:8];
                if (be[0]) ref_mem[a][7:0]  = d[7:0];
            end
        end
        q.push_back(e);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        cfg_mode = mode; cfg_wait = WAIT_W'(w); cfg_hold = HOLD_W'(h);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done();
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic access(input bit wr, input logic [7:0] a, input logic [15:0] d,
                          input logic [1:0] be, input bit mode, input int w, input int h);
        issue(wr, a, d, be, mode, w, h, 1'b0);
        wait_done();
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int mism;
        for (int i = 0; i < 256; i++) begin
            sram[i]    = {8'(i) ^ 8'h5A, ~8'(i)};
            ref_mem[i] = {8'(i) ^ 8'h5A, ~8'(i)};
        end
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        req_be = 2'b00; cfg_mode = 0; cfg_wait = '0; cfg_hold = '0;
        repeat (3) @(negedge clk);
        chk("R1", "pins inactive in reset",
            int'(mem_cs_n && mem_rd_n && mem_rdwr_n && (&mem_bs_n) && !mem_dq_oe && !rsp_done), 1);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk("R1", "pins inactive after reset",
            int'(mem_cs_n && mem_rd_n && mem_rdwr_n && (&mem_bs_n) && !mem_dq_oe && !rsp_done), 1);

        // Mode 0 writes and reads with several enable patterns (R5, R6, R10).
        access(1, 8'h10, 16'hA1B2, 2'b11, 0, 0, 0);
        access(0, 8'h10, 16'h0000, 2'b11, 0, 2, 0);
        access(1, 8'h11, 16'hC3D4, 2'b01, 0, 1, 0);
        access(0, 8'h11, 16'h0000, 2'b10, 0, 0, 0);
        access(0, 8'h11, 16'h0000, 2'b01, 0, 3, 0);
        // Mode 1 writes with hold counts 0, 3, 2 and reads (R7, R8).
        access(1, 8'h20, 16'h1357, 2'b11, 1, 0, 0);
        access(1, 8'h21, 16'h2468, 2'b10, 1, 3, 3);
        access(1, 8'h22, 16'h9ABC, 2'b01, 1, 1, 2);
        access(0, 8'h21, 16'h0000, 2'b11, 1, 1, 3);
        access(0, 8'h22, 16'h0000, 2'b11, 1, 0, 0);
        // Zero byte enables (R11).
        access(1, 8'h40, 16'hDEAD, 2'b00, 0, 2, 0);
        access(0, 8'h40, 16'h0000, 2'b00, 1, 2, 1);
        // Request and config changes during a busy access are ignored (R12).
        issue(0, 8'h30, 16'h0000, 2'b11, 0, 4, 0, 1'b1);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 8'h30; req_wdata = 16'hFFFF; req_be = 2'b11;
        cfg_mode = 1; cfg_wait = '0; cfg_hold = 2'd3;
        @(negedge clk);
        req_valid = 0;
        wait_done();
        issue(0, 8'h30, 16'h0000, 2'b11, 0, 0, 0, 1'b1);
        wait_done();
        // Longest wait (R4).
        access(1, 8'h50, 16'h0F0F, 2'b11, 1, 15, 1);
        access(0, 8'h50, 16'h0000, 2'b11, 0, 15, 0);

        repeat (4) @(negedge clk);
        mism = 0;
        for (int i = 0; i < 256; i++) if (sram[i] !== ref_mem[i]) mism++;
        chk("R5", "memory image mismatches", mism, 0);
        chk("R13", "pending expectations at end", q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule